// File: doc/BRIEF.md
# Two-Stage Randomized Sampling Interval Counter

This block watches a stream of population events (one strobe per counted operation) and raises a one-cycle selection pulse each time a programmed interval has elapsed. The interval is built from a 24-bit value supplied on an input. On request it is jittered in one of two ways. In the plain random mode, the low byte of each reload is a pseudorandom value. In the extended mode, the primary count reloads with a clean low byte and an 8-bit secondary countdown is armed with a pseudorandom value. The selection then waits until that secondary countdown also expires.

Both counters are packed into one 64-bit state word. Software can read it at any time and overwrite it, for example to save and restore it across a context switch. Software clears it to zero before a new sampling session. After a zero write, the next rising edge of the enable level loads a fresh interval. An internal free-running LFSR supplies the pseudorandom bytes. A build parameter removes the secondary counter altogether.

Top module: `samp_interval_ctr`

## Requirements
- R1: `rd_data` presents the primary count in bits 31:0 and the secondary count in bits 63:56. Bits 55:32 always read zero. When the design is built with `EXT_RND_EN=0`, bits 63:56 also read zero.
- R2: While `enable` is high, the primary count is nonzero and no write or start reload occurs, each `pop_evt` decrements the primary count by one.
- R3: A start reload occurs in a cycle where `enable` is high, it was low in the previous cycle, and the primary count is zero. It sets count bits 31:8 to `interval`. It sets bits 7:0 to a pseudorandom byte when `rnd_en`=1 and extended mode is off, and to 0x00 otherwise. A `pop_evt` in that cycle is not counted. A rising `enable` with a nonzero primary count changes nothing.
- R4: An event that takes the primary count from 1 to 0 reloads it in the same way as R3. When the secondary is not being armed, `sel_pulse` is high for exactly the one cycle after that event.
- R5: Extended mode is `xrnd_mode`=1 with `EXT_RND_EN`=1. When `rnd_en`=1 in extended mode, an event that empties the primary count loads the secondary count with a pseudorandom byte and raises no selection. The exception is a loaded byte of 0x00, which selects on that same event.
- R6: While the secondary count is nonzero, each counted event decrements both the secondary and the primary counts. The event that takes the secondary count from 1 to 0 raises `sel_pulse` in the next cycle.
- R7: While `enable` is low, neither count changes and `sel_pulse` stays low.
- R8: A cycle with `wr_en`=1 loads bits 31:0 and bits 63:56 of `wr_data` into the counts, visible on `rd_data` in the next cycle. A `pop_evt` in the same cycle is ignored.
- R9: Synchronous reset clears both counts and `sel_pulse` to zero.
- R10: The random low byte comes from a free-running maximal-length LFSR with a nonzero seed, so successive random reloads do not all carry the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Counting enable level |
| pop_evt | input | 1 | One population member in this cycle |
| interval | input | 24 | Interval value for reloads (count bits 31:8) |
| rnd_en | input | 1 | Randomize the interval |
| xrnd_mode | input | 1 | Use the secondary countdown for randomization |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Software write value |
| rd_data | output | 64 | Packed count state |
| sel_pulse | output | 1 | Registered one-cycle selection pulse |

## Verification
The bench aims at the edges of the count. It checks the 1-to-0 primary transition, which must reload and select exactly once; a design off by one would select one event early or late. It checks an event in the same cycle as a start reload or a software write, which must be dropped; a design that counted it would show a primary count one lower than the written or loaded value. It arms the secondary countdown and counts events to selection, whether or not the random byte is zero. A design that let the primary alone select would pulse early, and one that ignored a zero byte would miss the sample. It also checks that a rising enable with a nonzero count does not reload, and that a second instance built without the secondary counter reads zero in the top byte.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned DEF_REG_W  = 64;
  localparam int unsigned DEF_PRI_W  = 32;
  localparam int unsigned DEF_SEC_W  = 8;
  localparam int unsigned DEF_LFSR_W = 16;
  // Galois right-shift taps for x^16+x^14+x^13+x^11+1 (maximal length)
  localparam logic [DEF_LFSR_W-1:0] DEF_LFSR_TAPS = 16'hB400;
  localparam logic [DEF_LFSR_W-1:0] DEF_LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/sic_lfsr.sv
module sic_lfsr #(
  parameter int unsigned   W     = sic_pkg::DEF_LFSR_W,
  parameter int unsigned   OUT_W = sic_pkg::DEF_SEC_W,
  parameter logic [W-1:0]  TAPS  = sic_pkg::DEF_LFSR_TAPS,
  parameter logic [W-1:0]  SEED  = sic_pkg::DEF_LFSR_SEED
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SEED;
    end else if (st_q[0]) begin
      st_q <= (st_q >> 1) ^ TAPS;
    end else begin
      st_q <= st_q >> 1;
    end
  end

  assign rnd_o = st_q[OUT_W-1:0];
endmodule

// File: rtl/sic_primary.sv
module sic_primary #(
  parameter int unsigned PRI_W = sic_pkg::DEF_PRI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PRI_W-1:0] wr_val,
  input  logic             load_i,
  input  logic             evt_i,
  input  logic [PRI_W-1:0] reload_i,
  output logic [PRI_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [PRI_W-1:0] ONE = PRI_W'(1);

  logic [PRI_W-1:0] cnt_q;
  logic             nz;

  assign nz    = |cnt_q;
  assign hit_o = evt_i && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_en) begin
      cnt_q <= wr_val;
    end else if (load_i) begin
      cnt_q <= reload_i;
    end else if (evt_i && nz) begin
      cnt_q <= hit_o ? reload_i : cnt_q - ONE;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sic_secondary.sv
module sic_secondary #(
  parameter int unsigned SEC_W  = sic_pkg::DEF_SEC_W,
  parameter bit          EXT_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] wr_val,
  input  logic             evt_i,
  input  logic             arm_i,
  input  logic [SEC_W-1:0] seed_i,
  output logic [SEC_W-1:0] cnt_o,
  output logic             hit_o
);
  generate
    if (EXT_EN) begin : g_sec
      localparam logic [SEC_W-1:0] ONE = SEC_W'(1);
      logic [SEC_W-1:0] cnt_q;

      assign hit_o = evt_i && (cnt_q == ONE);

      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q <= '0;
        end else if (wr_en) begin
          cnt_q <= wr_val;
        end else if (arm_i) begin
          cnt_q <= seed_i;
        end else if (evt_i && (|cnt_q)) begin
          cnt_q <= cnt_q - ONE;
        end
      end

      assign cnt_o = cnt_q;
    end else begin : g_nosec
      logic unused_sec;
      assign unused_sec = ^{clk, rst, wr_en, wr_val, evt_i, arm_i, seed_i};
      assign cnt_o = '0;
      assign hit_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/samp_interval_ctr.sv
module samp_interval_ctr #(
  parameter int unsigned REG_W      = sic_pkg::DEF_REG_W,
  parameter int unsigned PRI_W      = sic_pkg::DEF_PRI_W,
  parameter int unsigned SEC_W      = sic_pkg::DEF_SEC_W,
  parameter int unsigned LFSR_W     = sic_pkg::DEF_LFSR_W,
  parameter bit          EXT_RND_EN = 1'b1,
  localparam int unsigned RND_W     = SEC_W,
  localparam int unsigned INTV_W    = PRI_W - RND_W,
  localparam int unsigned MID_W     = REG_W - PRI_W - SEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              pop_evt,
  input  logic [INTV_W-1:0] interval,
  input  logic              rnd_en,
  input  logic              xrnd_mode,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic              sel_pulse
);
  logic             en_q;
  logic             sel_q;
  logic [RND_W-1:0] rnd_byte;
  logic [PRI_W-1:0] pri_cnt;
  logic [SEC_W-1:0] sec_cnt;
  logic [PRI_W-1:0] reload_val;
  logic             pri_hit;
  logic             sec_hit;
  logic             xr_eff;
  logic             start_load;
  logic             evt_cnt;
  logic             arm;
  logic             sel_d;

  sic_lfsr #(
    .W     (LFSR_W),
    .OUT_W (RND_W)
  ) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .rnd_o (rnd_byte)
  );

  assign xr_eff     = EXT_RND_EN && xrnd_mode;
  assign reload_val = {interval, (rnd_en && !xr_eff) ? rnd_byte : {RND_W{1'b0}}};
  assign start_load = enable && !en_q && (pri_cnt == '0) && !wr_en;
  assign evt_cnt    = enable && pop_evt && !wr_en && !start_load;

  sic_primary #(
    .PRI_W (PRI_W)
  ) u_pri (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_val   (wr_data[PRI_W-1:0]),
    .load_i   (start_load),
    .evt_i    (evt_cnt),
    .reload_i (reload_val),
    .cnt_o    (pri_cnt),
    .hit_o    (pri_hit)
  );

  assign arm = pri_hit && rnd_en && xr_eff;

  sic_secondary #(
    .SEC_W  (SEC_W),
    .EXT_EN (EXT_RND_EN)
  ) u_sec (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_val (wr_data[REG_W-1 -: SEC_W]),
    .evt_i  (evt_cnt),
    .arm_i  (arm),
    .seed_i (rnd_byte),
    .cnt_o  (sec_cnt),
    .hit_o  (sec_hit)
  );

  assign sel_d = sec_hit || (pri_hit && !arm) || (arm && (rnd_byte == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      en_q  <= enable;
      sel_q <= sel_d;
    end
  end

  assign rd_data   = {sec_cnt, {MID_W{1'b0}}, pri_cnt};
  assign sel_pulse = sel_q;
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int unsigned REG_W      = 64,
  parameter int unsigned PRI_W      = 32,
  parameter int unsigned SEC_W      = 8,
  parameter bit          EXT_RND_EN = 1'b1,
  localparam int unsigned INTV_W    = PRI_W - SEC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              pop_evt,
  input logic [INTV_W-1:0] interval,
  input logic              wr_en,
  input logic [REG_W-1:0]  wr_data,
  input logic [REG_W-1:0]  rd_data,
  input logic              sel_pulse
);
  logic en_q;
  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enable;
  end

  logic [PRI_W-1:0] pri;
  assign pri = rd_data[PRI_W-1:0];

  AST_MID_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-SEC_W-1:PRI_W] == '0); // R1

  AST_PRI_DEC: assert property (@(posedge clk) disable iff (rst)
    (enable && en_q && pop_evt && !wr_en && (pri > PRI_W'(1))) |=> (pri == $past(pri) - PRI_W'(1))); // R2

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (enable && !en_q && !wr_en && (pri == '0)) |=> (rd_data[PRI_W-1:SEC_W] == $past(interval))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!enable && !wr_en) |=> (rd_data == $past(rd_data))); // R7

  AST_IDLE_NOSEL: assert property (@(posedge clk) disable iff (rst)
    (!enable || !pop_evt || wr_en) |=> !sel_pulse); // R7

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (pri == $past(wr_data[PRI_W-1:0]))); // R8

  generate
    if (!EXT_RND_EN) begin : g_nosec_chk
      AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1 -: SEC_W] == '0); // R1
    end
  endgenerate
endmodule

bind samp_interval_ctr sic_checker #(
  .REG_W      (REG_W),
  .PRI_W      (PRI_W),
  .SEC_W      (SEC_W),
  .EXT_RND_EN (EXT_RND_EN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .pop_evt   (pop_evt),
  .interval  (interval),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .sel_pulse (sel_pulse)
);

// File: tb/samp_interval_ctr_tb_top.sv
module samp_interval_ctr_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        pop_evt = 1'b0;
  logic [23:0] interval = '0;
  logic        rnd_en = 1'b0;
  logic        xrnd_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data, rd_data_nx;
  logic        sel_pulse, sel_pulse_nx;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  samp_interval_ctr dut_i (
    .clk(clk), .rst(rst), .enable(enable), .pop_evt(pop_evt), .interval(interval),
    .rnd_en(rnd_en), .xrnd_mode(xrnd_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sel_pulse(sel_pulse)
  );

  samp_interval_ctr #(.EXT_RND_EN(1'b0)) dut_nx_i (
    .clk(clk), .rst(rst), .enable(enable), .pop_evt(pop_evt), .interval(interval),
    .rnd_en(rnd_en), .xrnd_mode(xrnd_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data_nx), .sel_pulse(sel_pulse_nx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic sw_write(input logic [63:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic one_evt(output logic s);
    pop_evt = 1'b1;
    tick();
    pop_evt = 1'b0;
    s = sel_pulse;
  endtask

  task automatic run_evts(input int n, output int sels);
    logic s;
    sels = 0;
    for (int i = 0; i < n; i++) begin
      one_evt(s);
      if (s) sels++;
    end
  endtask

  task automatic t_reset();
    chk("R9 reset state", rd_data, 64'h0);
    chk("R9 reset sel", {63'h0, sel_pulse}, 64'h0);
  endtask

  task automatic t_layout();
    sw_write(64'hA5FF_FFFF_1234_5678);
    chk("R1 R8 layout", rd_data, 64'hA500_0000_1234_5678);
    chk("R1 no secondary build", rd_data_nx, 64'h0000_0000_1234_5678);
  endtask

  task automatic t_disabled();
    int sels;
    enable = 1'b0;
    run_evts(5, sels);
    chk("R7 hold while disabled", rd_data, 64'hA500_0000_1234_5678);
    chk("R7 no select while disabled", 64'(sels), 64'h0);
  endtask

  task automatic t_plain();
    int  sels;
    logic s;
    sw_write(64'h0);
    interval = 24'h3; rnd_en = 1'b0; xrnd_mode = 1'b0;
    enable = 1'b0; tick();
    enable = 1'b1; pop_evt = 1'b1; tick(); pop_evt = 1'b0;
    chk("R3 start reload, event dropped", rd_data, 64'h300);
    one_evt(s);
    chk("R2 decrement", rd_data, 64'h2FF);
    enable = 1'b0; tick(); enable = 1'b1; tick();
    chk("R3 no reload when nonzero", rd_data, 64'h2FF);
    run_evts(766, sels);
    chk("R2 count down to one", rd_data, 64'h1);
    chk("R4 no early select", 64'(sels), 64'h0);
    one_evt(s);
    chk("R4 select on zero", {63'h0, s}, 64'h1);
    chk("R4 reload on zero", rd_data, 64'h300);
    tick();
    chk("R4 pulse one cycle", {63'h0, sel_pulse}, 64'h0);
  endtask

  task automatic t_rnd_low();
    logic [7:0] lb [6];
    int distinct = 0;
    int n = 0;
    logic s = 1'b0;
    interval = 24'h1; rnd_en = 1'b1; xrnd_mode = 1'b0;
    for (int k = 0; k < 6; k++) begin
      enable = 1'b0;
      sw_write(64'h0);
      repeat (k + 1) tick();
      enable = 1'b1; tick();
      lb[k] = rd_data[7:0];
      chk("R3 random reload upper", {rd_data[63:8], 8'h0}, 64'h100);
    end
    for (int k = 1; k < 6; k++) if (lb[k] != lb[0]) distinct++;
    chk("R10 random bytes vary", 64'(distinct != 0), 64'h1);
    while (!s && n < 600) begin
      one_evt(s);
      n++;
    end
    chk("R4 events to select with random low", 64'(n), 64'(256 + int'(lb[5])));
    chk("R4 random reload after select", {rd_data[63:8], 8'h0}, 64'h100);
  endtask

  task automatic t_secondary();
    int sels;
    logic s;
    logic [7:0] b;
    interval = 24'h1; rnd_en = 1'b1; xrnd_mode = 1'b1;
    enable = 1'b0;
    sw_write(64'h0);
    enable = 1'b1; tick();
    chk("R3 extended mode low byte zero", rd_data, 64'h100);
    run_evts(255, sels);
    chk("R2 primary at one", rd_data, 64'h1);
    one_evt(s);
    b = rd_data[63:56];
    chk("R5 primary reloads when arming", {32'h0, rd_data[31:0]}, 64'h100);
    if (b == 8'h0) begin
      chk("R5 zero byte selects at once", {63'h0, s}, 64'h1);
    end else begin
      chk("R5 arming does not select", {63'h0, s}, 64'h0);
      run_evts(int'(b) - 1, sels);
      chk("R6 no select before secondary empties", 64'(sels), 64'h0);
      chk("R6 both counts decrement",
          rd_data, {8'h1, 24'h0, 32'h100 - 32'(int'(b) - 1)});
      one_evt(s);
      chk("R6 select when secondary empties", {63'h0, s}, 64'h1);
      chk("R6 counts after select", rd_data, {8'h0, 24'h0, 32'h100 - 32'(b)});
    end
  endtask

  task automatic t_write_prio();
    logic s;
    xrnd_mode = 1'b1;
    pop_evt = 1'b1;
    sw_write(64'h0200_0000_0000_000A);
    pop_evt = 1'b0;
    chk("R8 write beats event", rd_data, 64'h0200_0000_0000_000A);
    one_evt(s);
    chk("R6 written secondary decrements", rd_data, 64'h0100_0000_0000_0009);
    chk("R6 no select yet", {63'h0, s}, 64'h0);
    one_evt(s);
    chk("R6 select from written secondary", {63'h0, s}, 64'h1);
    chk("R6 counts after written select", rd_data, 64'h0000_0000_0000_0008);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_layout();
    t_disabled();
    t_plain();
    t_rnd_low();
    t_secondary();
    t_write_prio();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule